// File: doc/BRIEF.md
# Self-Describing Bus Access Tester

This block is a memory-mapped target that a host uses to check its own low-level access paths. It decodes a window of up to 4 KB behind a plain 32-bit register bus. The bus has a byte address, four byte enables, separate read and write strobes, write data and registered read data. The target always accepts and never stalls, so there is no back-pressure: every strobe completes, and read data comes back exactly one cycle later.

A small header at the bottom of the window tells the host what to do. The host writes a test number to the first header byte. It then reads back the access width, the byte offset and the data value for that test, together with a short ASCII name. It issues the write it has been told to make and reads the counter to confirm that the write arrived intact. To discover the tests, the host increments the test number until the reported width is zero.

Top module: `bus_access_tester`

## Requirements
- R1: After reset, test 0 is active and the detected-write counter is 0, so header word 0 reads as 0x00000100.
- R2: The test table is fixed. Test 0 is width 1 at offset 0x100 with value 0x000000A5. Test 1 is width 2 at offset 0x202 with value 0x0000BEEF. Test 2 is width 4 at offset 0x304 with value 0x12345678.
- R3: Any test number of 3 or above reports width 0, offset 0, value 0 and an empty name.
- R4: A write to byte address 0 with byte enable bit 0 set selects the test given by wdata[7:0]. Header word 0 reads with bits 7:0 as zero (the test number is write-only), the width in bits 15:8, and zero in bits 31:16.
- R5: The header words are little endian. The offset is at 0x004, the value at 0x008 and the counter at 0x00C.
- R6: A write is detected only when all three of these hold:
  - its byte address equals the advertised offset;
  - its byte enables equal the width's lane mask shifted left by offset[1:0] (mask 0001 for width 1, 0011 for width 2, 1111 for width 4);
  - its enabled lanes carry the value shifted left by 8*offset[1:0].
  Each detected write adds one to the counter.
- R7: Writes that miss on address, byte enables or data leave the counter unchanged.
- R8: Every test selection clears the counter, including re-selection of the test that is already active.
- R9: Writes to the read-only header fields (bytes 1 to 15) change neither the test, its fields nor the counter.
- R10: Reads of unmapped space, or beyond the 8-byte name field, return 0.
- R11: Read data appears in the cycle after the read strobe and holds until the next read. A read that coincides with a write returns the counter value from before that write.
- R12: The name occupies bytes 0x010 to 0x017, one character per byte starting at the lowest byte, and is zero-terminated. The names are "BYTE" for test 0, "HALF" for test 1 and "WORD" for test 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| be | input | 4 | Byte enables for the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench sends writes that miss by exactly one attribute: the byte address is off by one lane, the half-word enable is misplaced, or one data lane is wrong. A matcher that ignored any one of these would raise the counter. The bench re-selects the active test and expects the counter to clear; a design that compared against the old test number would keep counting. It steps past the last test, where any leftover table entry would show a non-zero width or name. It writes over the read-only header, which would corrupt the advertised fields in a design that decoded those writes. A long seeded random mix of selects, writes and reads is then compared word by word against a bench model.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int NUM_TESTS = 3;
  localparam int LANES     = 4;

  typedef struct packed {
    logic [7:0]  width;
    logic [31:0] offset;
    logic [31:0] pattern;
    logic [63:0] name;
  } test_desc_t;

  // Names are packed with the first character in the lowest byte.
  function automatic test_desc_t lookup(input logic [7:0] num);
    test_desc_t d;
    d = '0;
    case (num)
      8'd0: begin
        d.width = 8'd1; d.offset = 32'h100; d.pattern = 32'h0000_00A5;
        d.name = {32'h0, 32'h4554_5942};
      end
      8'd1: begin
        d.width = 8'd2; d.offset = 32'h202; d.pattern = 32'h0000_BEEF;
        d.name = {32'h0, 32'h464C_4148};
      end
      8'd2: begin
        d.width = 8'd4; d.offset = 32'h304; d.pattern = 32'h1234_5678;
        d.name = {32'h0, 32'h4452_4F57};
      end
      default: d = '0;
    endcase
    return d;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [7:0] width, input logic [1:0] lo);
    case (width)
      8'd1:    return 4'b0001 << lo;
      8'd2:    return 4'b0011 << lo;
      8'd4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/bat_table.sv
module bat_table
  import bat_pkg::*;
(
  input  logic [7:0] test_num,
  output test_desc_t desc
);
  always_comb desc = lookup(test_num);
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [31:0]       wdata,
  input  logic [7:0]        width,
  input  logic [31:0]       offset,
  input  logic [31:0]       pattern,
  output logic              hit
);
  logic [LANES-1:0] want_be;
  logic [LANES-1:0] lane_ok;
  logic [31:0]      placed;

  always_comb want_be = lane_mask(width, offset[1:0]);
  assign placed = pattern << {offset[1:0], 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_ok[g] = !want_be[g] || (wdata[8*g +: 8] == placed[8*g +: 8]);
  end

  assign hit = wr_en && (want_be != '0) && (32'(addr) == offset) &&
               (be == want_be) && (&lane_ok);
endmodule

// File: rtl/bat_counter.sv
module bat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (inc)     count <= count + 1'b1;
  end

  p_clear_r8: assert property (@(posedge clk) disable iff (rst) clear |=> count == '0);
  p_step_r6:  assert property (@(posedge clk) disable iff (rst)
                inc && !clear |=> count == $past(count) + 1'b1);
  p_hold_r7:  assert property (@(posedge clk) disable iff (rst)
                !inc && !clear |=> $stable(count));
endmodule

// File: rtl/bus_access_tester.sv
module bus_access_tester
  import bat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [7:0]       test_num;
  test_desc_t       desc;
  logic             sel;
  logic             hit;
  logic [CNT_W-1:0] count;
  logic [WIDX_W-1:0] widx;
  logic [31:0]      rd_mux;

  assign widx = addr[ADDR_W-1:2];
  assign sel  = wr_en && (widx == '0) && be[0];

  always_ff @(posedge clk) begin
    if (rst)      test_num <= '0;
    else if (sel) test_num <= wdata[7:0];
  end

  bat_table u_table (.test_num(test_num), .desc(desc));

  bat_matcher #(.ADDR_W(ADDR_W)) u_match (
    .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata),
    .width(desc.width), .offset(desc.offset), .pattern(desc.pattern), .hit(hit)
  );

  bat_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clear(sel), .inc(hit), .count(count)
  );

  always_comb begin
    case (widx)
      WIDX_W'(0): rd_mux = {16'h0, desc.width, 8'h0};
      WIDX_W'(1): rd_mux = desc.offset;
      WIDX_W'(2): rd_mux = desc.pattern;
      WIDX_W'(3): rd_mux = 32'(count);
      WIDX_W'(4): rd_mux = desc.name[31:0];
      WIDX_W'(5): rd_mux = desc.name[63:32];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rdata));
  p_unsupported_r3: assert property (@(posedge clk) disable iff (rst)
                      test_num >= 8'(NUM_TESTS) |-> desc.width == 8'd0);
  p_hit_width_r6:   assert property (@(posedge clk) disable iff (rst)
                      hit |-> 8'($countones(be)) == desc.width);
  p_ro_header_r9:   assert property (@(posedge clk) disable iff (rst)
                      wr_en && !sel |=> $stable(test_num));
endmodule

// File: tb/test_bus_access_tester.sv
module test_bus_access_tester;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int nvec = 0;
  int nerr = 0;
  int m_test = 0;
  int m_count = 0;

  always #5 clk = ~clk;

  bus_access_tester i_bus_access_tester (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .be(be), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] x_width(int t);
    return (t == 0) ? 8'd1 : (t == 1) ? 8'd2 : (t == 2) ? 8'd4 : 8'd0;
  endfunction
  function automatic logic [31:0] x_off(int t);
    return (t == 0) ? 32'h100 : (t == 1) ? 32'h202 : (t == 2) ? 32'h304 : 32'h0;
  endfunction
  function automatic logic [31:0] x_val(int t);
    return (t == 0) ? 32'hA5 : (t == 1) ? 32'hBEEF : (t == 2) ? 32'h12345678 : 32'h0;
  endfunction
  function automatic logic [31:0] x_name(int t);
    return (t == 0) ? {"E","T","Y","B"} : (t == 1) ? {"F","L","A","H"} :
           (t == 2) ? {"D","R","O","W"} : 32'h0;
  endfunction
  function automatic logic [31:0] x_word(int t, int c, int w);
    case (w)
      0: return {16'h0, x_width(t), 8'h0};
      1: return x_off(t);
      2: return x_val(t);
      3: return c;
      4: return x_name(t);
      default: return 32'h0;
    endcase
  endfunction
  function automatic bit x_hit(int t, logic [11:0] a, logic [3:0] b, logic [31:0] d);
    logic [3:0] m; logic [31:0] want;
    int lo;
    lo = int'(x_off(t) & 32'h3);
    if (x_width(t) == 0 || {20'h0, a} != x_off(t)) return 0;
    m = (x_width(t) == 1) ? 4'b0001 << lo : (x_width(t) == 2) ? 4'b0011 << lo : 4'hF;
    if (b != m) return 0;
    want = x_val(t) << (8 * lo);
    for (int i = 0; i < 4; i++)
      if (m[i] && d[8*i +: 8] != want[8*i +: 8]) return 0;
    return 1;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_write(logic [11:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk); addr = a; be = b; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; be = '0;
    if (a[11:2] == 0 && b[0]) begin m_test = int'(d[7:0]); m_count = 0; end
    else if (x_hit(m_test, a, b, d)) m_count++;
  endtask

  task automatic do_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic read_check(string tag, logic [11:0] a);
    logic [31:0] d;
    do_read(a, d);
    check(tag, d, x_word(m_test, m_count, int'(a[11:2])));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R11 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    do_read(12'h000, d); check("R1 word0", d, 32'h00000100);
    do_read(12'h00C, d); check("R1 count", d, 32'h0);
    // R2 R3 R4 R5 R12 walk the table and beyond
    for (int t = 0; t < 5; t++) begin
      do_write(12'h000, 4'b0001, t);
      for (int w = 0; w < 6; w++) read_check(t < 3 ? "R2 R5 R12 field" : "R3 unsupported", 12'(4 * w));
    end
    do_read(12'h010, d); check("R12 name of test 4 empty", d, 32'h0);
    // R6 R7 R8 test 0
    do_write(12'h000, 4'b0001, 0);
    do_write(12'h100, 4'b0001, 32'hFFFF_FFA5);
    do_read(12'h00C, d); check("R6 byte hit", d, 1);
    do_write(12'h100, 4'b0011, 32'hA5);
    do_write(12'h100, 4'b0001, 32'hA4);
    do_write(12'h101, 4'b0010, 32'hA500);
    do_read(12'h00C, d); check("R7 misses", d, 1);
    do_write(12'h000, 4'b0001, 0);
    do_read(12'h00C, d); check("R8 reselect clears", d, 0);
    // test 1 half word on upper lanes
    do_write(12'h000, 4'b0001, 1);
    do_write(12'h202, 4'b1100, 32'hBEEF_0000);
    do_write(12'h202, 4'b0110, 32'h00BE_EF00);
    do_write(12'h202, 4'b1100, 32'hBEEE_0000);
    do_read(12'h00C, d); check("R6 R7 half", d, 1);
    // test 2 word
    do_write(12'h000, 4'b0001, 2);
    do_write(12'h304, 4'b1111, 32'h1234_5678);
    do_write(12'h304, 4'b1111, 32'h1234_5678);
    do_write(12'h300, 4'b1111, 32'h1234_5678);
    do_read(12'h00C, d); check("R6 word", d, 2);
    // R9 read-only header writes
    do_write(12'h000, 4'b1110, 32'hFFFF_FFFF);
    do_write(12'h004, 4'b1111, 32'h0000_0304);
    do_write(12'h008, 4'b1111, 32'hDEAD_BEEF);
    do_write(12'h00C, 4'b1111, 32'h0000_0055);
    for (int w = 0; w < 4; w++) read_check("R9 header unchanged", 12'(4 * w));
    // R10 unmapped
    do_read(12'h018, d); check("R10 past name", d, 0);
    do_read(12'h800, d); check("R10 unmapped", d, 0);
    do_read(12'hFFC, d); check("R10 top", d, 0);
    // R11 latency and hold
    do_read(12'h008, d); check("R11 one cycle", d, 32'h12345678);
    @(negedge clk); @(negedge clk); check("R11 hold", rdata, 32'h12345678);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      int t;
      logic [11:0] a;
      logic [31:0] v;
      op = int'($urandom_range(0, 9));
      if (op == 0) do_write(12'h000, 4'b0001, $urandom_range(0, 4));
      else if (op < 6) begin
        t = m_test;
        a = ($urandom_range(0, 3) == 0) ? 12'($urandom) : x_off(t) [11:0];
        v = ($urandom_range(0, 1) == 0) ? x_val(t) << (8 * (x_off(t) & 3)) : $urandom;
        do_write(a, ($urandom_range(0, 1) == 0) ?
                 ((x_width(t) == 1) ? 4'b0001 << (x_off(t) & 3) :
                  (x_width(t) == 2) ? 4'b0011 << (x_off(t) & 3) : 4'hF) : 4'($urandom),
                 v);
      end else read_check("R6 R7 R10 random", 12'(4 * $urandom_range(0, 9)));
    end
    read_check("R6 final count", 12'h00C);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule